// File: doc/BRIEF.md
# Maskable Interrupt Request Collector

This block gathers interrupt requests for a small controller core from two groups of sources: a set of external input pins and a set of internal event pulses. The internal pulses come from a clock prescaler, a reload timer and a serial output buffer. Each source owns a sticky request flag. A flag is set when its source fires. It stays set until the core reads the register of its group, and that read clears it. A per-source enable bit decides whether a flag takes part in the combined request. A global enable further gates the interrupt line to the core. A separate wake line ignores the global enable, so an enabled request can end the halted standby state even while the core has interrupts turned off.

Each external pin first goes through a two-stage synchronizer. After that it is used either directly or through a debouncer, as chosen per pin. The debouncer accepts a new level only after it has seen that level on three consecutive ticks of a slow sampling strobe. Each pin also selects whether its rising or its falling edge raises the request.

Top module: `intr_gather`

## Requirements
- R1: After reset both flag groups read zero, and `irq_o` and `wake_o` are low.
- R2: With `deb_sel_i[i]=0` and `fall_sel_i[i]=0`, a low-to-high change on `ext_pin_i[i]` sets `ext_flags_o[i]`. The flag is visible after the third rising clock edge that follows the change. A high-to-low change sets nothing.
- R3: With `fall_sel_i[i]=1`, only a high-to-low change on pin i sets its flag, with the same latency as R2. A rising change sets nothing.
- R4: With `deb_sel_i[i]=1`, the pin's level is accepted only when three consecutive `deb_tick_i` strobes all see the new synchronized level. The flag appears one clock edge after the accepting strobe. A level that reverts before the third strobe sets no flag.
- R5: Internal flag bit 0 belongs to the prescaler, bit 1 to the timer and bit 2 to the serial buffer. A one-cycle pulse on `int_evt_i[k]` sets `int_flags_o[k]` at the next clock edge.
- R6: A flag stays set until its group is read. A cycle with `rd_ext_i` (or `rd_int_i`) high clears that group's flags at the closing clock edge. The other group is left unchanged.
- R7: An event that arrives in the same cycle as the clearing read of its group leaves its flag set.
- R8: `mask_i` bits [3:0] enable external pins 0..3 and bits [6:4] enable internal flags 0..2. A disabled source still sets its flag but drives neither `irq_o` nor `wake_o`.
- R9: `irq_o` is high exactly when `glob_en_i` is high and some flag is set together with its enable bit. `wake_o` follows the same rule without `glob_en_i`.
- R10: External flag bit i belongs to `ext_pin_i[i]` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin_i | input | 4 | External request pins, asynchronous |
| deb_tick_i | input | 1 | Debouncer sampling strobe, one cycle wide |
| fall_sel_i | input | 4 | Per pin: 1 = falling edge, 0 = rising edge |
| deb_sel_i | input | 4 | Per pin: 1 = debounced path, 0 = direct path |
| int_evt_i | input | 3 | Internal event pulses: prescaler, timer, serial buffer |
| mask_i | input | 7 | Per-source enable bits |
| glob_en_i | input | 1 | Global interrupt enable |
| rd_ext_i | input | 1 | Read strobe of the external flag group |
| rd_int_i | input | 1 | Read strobe of the internal flag group |
| ext_flags_o | output | 4 | External flag group, the read data |
| int_flags_o | output | 3 | Internal flag group, the read data |
| irq_o | output | 1 | Combined interrupt request to the core |
| wake_o | output | 1 | Request to leave the halted standby state |

## Verification
On the direct path a pin change reaches its flag three rising edges later: two synchronizer stages plus the flag register. The bench checks one edge early that the flag is still clear, and then checks that it is set. A debounced pin flags one edge after its third accepting strobe. An internal pulse and a clearing read both act at the first edge. `irq_o` and `wake_o` follow flags, enables and the global enable in the same cycle. Every input is driven on the falling clock edge. Every output is sampled on a later falling edge, after the exact number of rising edges counted from the stimulus.

// File: rtl/intr_pkg.sv
package intr_pkg;
  parameter int N_EXT_PINS   = 4;
  parameter int N_INT_SRCS   = 3;
  parameter int N_SYNC_STG   = 2;
  parameter int N_DEB_TICKS  = 3;

  typedef enum logic [1:0] {
    SRC_PRESC = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_SERBUF = 2'd2
  } int_src_e;
endpackage

// File: rtl/rst_release.sv
module rst_release (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d_i;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce #(
  parameter int SAMPLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int CW = (SAMPLES < 2) ? 1 : $clog2(SAMPLES);
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic          acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (tick_i) begin
      if (lvl_i != acc_q) begin
        if (cnt_q == LAST) begin
          acc_d = lvl_i;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick_i) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl_o = acc_q;
endmodule

// File: rtl/edge_pick.sv
module edge_pick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic clean_i,
  input  logic use_clean_i,
  input  logic fall_i,
  output logic hit_o
);
  logic lvl;
  logic prev_q;

  assign lvl = use_clean_i ? clean_i : raw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign hit_o = fall_i ? (prev_q & ~lvl) : (lvl & ~prev_q);
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flg_q, flg_d;

  always_comb begin
    flg_d = (flg_q & {W{~clr_i}}) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= flg_d;
  end

  assign flags_o = flg_q;
endmodule

// File: rtl/intr_gather.sv
module intr_gather #(
  parameter int NUM_EXT  = intr_pkg::N_EXT_PINS,
  parameter int NUM_INT  = intr_pkg::N_INT_SRCS,
  parameter int SYNC_STG = intr_pkg::N_SYNC_STG,
  parameter int DEB_N    = intr_pkg::N_DEB_TICKS,
  localparam int NUM_SRC = NUM_EXT + NUM_INT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_pin_i,
  input  logic               deb_tick_i,
  input  logic [NUM_EXT-1:0] fall_sel_i,
  input  logic [NUM_EXT-1:0] deb_sel_i,
  input  logic [NUM_INT-1:0] int_evt_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               glob_en_i,
  input  logic               rd_ext_i,
  input  logic               rd_int_i,
  output logic [NUM_EXT-1:0] ext_flags_o,
  output logic [NUM_INT-1:0] int_flags_o,
  output logic               irq_o,
  output logic               wake_o
);
  logic               rst_n_s;
  logic [NUM_EXT-1:0] pin_sync_lvl;
  logic [NUM_EXT-1:0] pin_deb_lvl;
  logic [NUM_EXT-1:0] pin_hit;
  logic [NUM_SRC-1:0] all_flags;
  logic               any_enabled;

  rst_release u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rst_n_o (rst_n_s)
  );

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
    pin_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_n_s),
      .d_i    (ext_pin_i[i]),
      .q_o    (pin_sync_lvl[i])
    );

    pin_debounce #(.SAMPLES(DEB_N)) u_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_n_s),
      .tick_i (deb_tick_i),
      .lvl_i  (pin_sync_lvl[i]),
      .lvl_o  (pin_deb_lvl[i])
    );

    edge_pick u_edge (
      .clk_i       (clk_i),
      .rst_ni      (rst_n_s),
      .raw_i       (pin_sync_lvl[i]),
      .clean_i     (pin_deb_lvl[i]),
      .use_clean_i (deb_sel_i[i]),
      .fall_i      (fall_sel_i[i]),
      .hit_o       (pin_hit[i])
    );
  end

  flag_bank #(.W(NUM_EXT)) u_ext_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .set_i   (pin_hit),
    .clr_i   (rd_ext_i),
    .flags_o (ext_flags_o)
  );

  flag_bank #(.W(NUM_INT)) u_int_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .set_i   (int_evt_i),
    .clr_i   (rd_int_i),
    .flags_o (int_flags_o)
  );

  assign all_flags   = {int_flags_o, ext_flags_o};
  assign any_enabled = |(all_flags & mask_i);
  assign wake_o      = any_enabled;
  assign irq_o       = any_enabled & glob_en_i;
endmodule

// File: rtl/intr_gather_chk.sv
module intr_gather_chk #(
  parameter int NUM_EXT = 4,
  parameter int NUM_INT = 3
) (
  input logic               clk_i,
  input logic               rst_n_s,
  input logic [NUM_INT-1:0] int_evt_i,
  input logic               rd_ext_i,
  input logic               rd_int_i,
  input logic               glob_en_i,
  input logic [NUM_EXT-1:0] ext_flags_o,
  input logic [NUM_INT-1:0] int_flags_o,
  input logic               irq_o,
  input logic               wake_o
);
  p_ext_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !rd_ext_i |=> ((ext_flags_o & $past(ext_flags_o)) == $past(ext_flags_o)));

  p_int_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !rd_int_i |=> ((int_flags_o & $past(int_flags_o)) == $past(int_flags_o)));

  // R7: after a read only the same-cycle events may remain
  p_read_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    rd_int_i |=> ((int_flags_o & ~$past(int_evt_i)) == '0));

  p_evt_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (int_evt_i != '0) |=> ((int_flags_o & $past(int_evt_i)) == $past(int_evt_i)));

  p_irq_glob_r9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    irq_o |-> glob_en_i);

  p_irq_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    irq_o |-> wake_o);

  p_wake_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    wake_o |-> ((ext_flags_o != '0) || (int_flags_o != '0)));
endmodule

bind intr_gather intr_gather_chk #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT)) chk_i (
  .clk_i       (clk_i),
  .rst_n_s     (rst_n_s),
  .int_evt_i   (int_evt_i),
  .rd_ext_i    (rd_ext_i),
  .rd_int_i    (rd_int_i),
  .glob_en_i   (glob_en_i),
  .ext_flags_o (ext_flags_o),
  .int_flags_o (int_flags_o),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/intr_gather_tb_top.sv
module intr_gather_tb_top;
  localparam int NE = 4;
  localparam int NI = 3;
  localparam int NS = NE + NI;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [NE-1:0] ext_pin;
  logic          deb_tick;
  logic [NE-1:0] fall_sel;
  logic [NE-1:0] deb_sel;
  logic [NI-1:0] int_evt;
  logic [NS-1:0] mask;
  logic          glob_en;
  logic          rd_ext;
  logic          rd_int;
  logic [NE-1:0] ext_flags;
  logic [NI-1:0] int_flags;
  logic          irq;
  logic          wake;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  intr_gather dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ext_pin_i   (ext_pin),
    .deb_tick_i  (deb_tick),
    .fall_sel_i  (fall_sel),
    .deb_sel_i   (deb_sel),
    .int_evt_i   (int_evt),
    .mask_i      (mask),
    .glob_en_i   (glob_en),
    .rd_ext_i    (rd_ext),
    .rd_int_i    (rd_int),
    .ext_flags_o (ext_flags),
    .int_flags_o (int_flags),
    .irq_o       (irq),
    .wake_o      (wake)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_ext();
    rd_ext = 1'b1; cyc(1); rd_ext = 1'b0;
  endtask

  task automatic read_int();
    rd_int = 1'b1; cyc(1); rd_int = 1'b0;
  endtask

  task automatic strobe();
    deb_tick = 1'b1; cyc(1); deb_tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ext flags", 8'(ext_flags), 8'h0);
    chk("R1 int flags", 8'(int_flags), 8'h0);
    chk("R1 irq", 8'(irq), 8'h0);
    chk("R1 wake", 8'(wake), 8'h0);
  endtask

  task automatic t_direct_rise();
    ext_pin[0] = 1'b1;
    cyc(2);
    chk("R2 not yet", 8'(ext_flags), 8'h0);
    cyc(1);
    chk("R2 rise flag", 8'(ext_flags), 8'h1);
    chk("R9 irq on", 8'(irq), 8'h1);
    cyc(3);
    chk("R6 held", 8'(ext_flags), 8'h1);
    int_evt = 3'b010; cyc(1); int_evt = '0;
    read_ext();
    chk("R6 ext cleared", 8'(ext_flags), 8'h0);
    chk("R6 int untouched", 8'(int_flags), 8'h2);
    read_int();
    ext_pin[0] = 1'b0;
    cyc(4);
    chk("R2 fall ignored", 8'(ext_flags), 8'h0);
  endtask

  task automatic t_pin_map();
    ext_pin[2] = 1'b1;
    cyc(3);
    chk("R10 pin2 only", 8'(ext_flags), 8'h4);
    read_ext();
    ext_pin[2] = 1'b0;
    cyc(4);
  endtask

  task automatic t_falling();
    fall_sel[1] = 1'b1;
    ext_pin[1] = 1'b1;
    cyc(4);
    chk("R3 rise ignored", 8'(ext_flags), 8'h0);
    ext_pin[1] = 1'b0;
    cyc(2);
    chk("R3 not yet", 8'(ext_flags), 8'h0);
    cyc(1);
    chk("R3 fall flag", 8'(ext_flags), 8'h2);
    read_ext();
    fall_sel[1] = 1'b0;
  endtask

  task automatic t_debounce();
    deb_sel[0] = 1'b1;
    ext_pin[0] = 1'b1;
    cyc(3);
    strobe(); strobe();
    chk("R4 two strobes", 8'(ext_flags), 8'h0);
    ext_pin[0] = 1'b0;
    cyc(3);
    strobe();
    ext_pin[0] = 1'b1;
    cyc(3);
    strobe(); strobe();
    chk("R4 glitch rejected", 8'(ext_flags), 8'h0);
    strobe();
    chk("R4 accept edge", 8'(ext_flags), 8'h0);
    cyc(1);
    chk("R4 debounced flag", 8'(ext_flags), 8'h1);
    read_ext();
    ext_pin[0] = 1'b0;
    cyc(3);
    strobe(); strobe(); strobe();
    cyc(2);
    chk("R4 release no flag", 8'(ext_flags), 8'h0);
    deb_sel[0] = 1'b0;
    cyc(2);
  endtask

  task automatic t_internal();
    for (int k = 0; k < NI; k++) begin
      int_evt = NI'(1 << k);
      cyc(1);
      int_evt = '0;
      chk("R5 internal source", 8'(int_flags), 8'(1 << k));
      read_int();
      chk("R6 int cleared", 8'(int_flags), 8'h0);
    end
  endtask

  task automatic t_coincide();
    int_evt = 3'b001; cyc(1);
    int_evt = 3'b010; rd_int = 1'b1; cyc(1);
    int_evt = '0; rd_int = 1'b0;
    chk("R7 event during read", 8'(int_flags), 8'h2);
    read_int();
  endtask

  task automatic t_mask();
    mask = '0; glob_en = 1'b1;
    int_evt = 3'b100; cyc(1); int_evt = '0;
    chk("R8 masked flag set", 8'(int_flags), 8'h4);
    chk("R8 masked irq", 8'(irq), 8'h0);
    chk("R8 masked wake", 8'(wake), 8'h0);
    mask = 7'b100_0000; #1;
    chk("R9 enabled irq", 8'(irq), 8'h1);
    glob_en = 1'b0; #1;
    chk("R9 global off irq", 8'(irq), 8'h0);
    chk("R9 global off wake", 8'(wake), 8'h1);
    mask = 7'b000_0001; #1;
    chk("R8 other mask wake", 8'(wake), 8'h0);
    cyc(1);
    read_int();
    mask = '1; glob_en = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; ext_pin = '0; deb_tick = 1'b0; fall_sel = '0; deb_sel = '0;
    int_evt = '0; mask = '1; glob_en = 1'b1; rd_ext = 1'b0; rd_int = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(3);
    t_reset();
    t_direct_rise();
    t_pin_map();
    t_falling();
    t_debounce();
    t_internal();
    t_coincide();
    t_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule